// File: doc/BRIEF.md
# Operating Mode, Privilege and Banked Stack Pointer Controller

This block keeps the processor core's execution context. It records whether the core runs application code (thread mode) or an exception service routine (handler mode), and whether thread code runs privileged or unprivileged. It also holds two banked stack pointers, a main one and a process one. Only one of them is visible through the single stack register at a time.

A control-register write lets privileged thread code drop to the unprivileged level or move to the process stack. Unprivileged code cannot regain privilege this way: the only path back is exception entry. Entry forces handler mode, the privileged level and the main stack. Exception return either loads a return state supplied with the request or restores the state captured at the most recent entry. A denied attempt to raise privilege is reported on a one-cycle flag.

Top module: `priv_stack_ctrl`

## Requirements
- R1: After reset the block reports thread mode (`handler_mode`=0), privileged level (`user_level`=0) and the main stack (`stack_sel`=0). Both banked pointers are 0 and `illegal_wr` is 0.
- R2: On the clock edge that samples `exc_entry`=1, the block moves to handler mode at privileged level with the main stack selected. The outputs show this from that edge on. Entry wins over an exception return or control write in the same cycle, and those are then discarded.
- R3: An exception return with `ret_explicit`=1 loads mode, privilege and stack select from `ret_handler`, `ret_user` and `ret_psp`.
- R4: An exception return with `ret_explicit`=0 restores the mode, privilege and stack select that were in effect just before the most recent exception entry. An exception return wins over a control write in the same cycle, and the write is discarded.
- R5: A control write (`ctrl_wr`) from privileged code stores `ctrl_wdata[0]` (1 = unprivileged thread) and `ctrl_wdata[1]` (1 = process stack in thread mode). The new values take effect from the next edge.
- R6: A control write at the unprivileged level with `ctrl_wdata[0]`=0 changes no state. It drives `illegal_wr` high for exactly the one cycle after that edge.
- R7: A control write at the unprivileged level with `ctrl_wdata[0]`=1 changes nothing and raises no flag. This includes any attempt to change the stack select.
- R8: A stack write (`sp_wr`) updates only the bank that is selected before the edge, with bits [1:0] stored as zero. The other bank keeps its value, and `sp_value` always has bits [1:0] equal to zero.
- R9: In handler mode the outputs always show the privileged level and the main stack, whatever control bits are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_entry | input | 1 | Exception entry request |
| exc_return | input | 1 | Exception return request |
| ret_explicit | input | 1 | 1: use the supplied return state; 0: restore the saved state |
| ret_handler | input | 1 | Supplied return mode (1 = handler) |
| ret_user | input | 1 | Supplied return privilege (1 = unprivileged) |
| ret_psp | input | 1 | Supplied return stack select (1 = process) |
| ctrl_wr | input | 1 | Control-register write strobe |
| ctrl_wdata | input | 2 | Bit 0: unprivileged thread; bit 1: process stack |
| sp_wr | input | 1 | Stack register write strobe |
| sp_wdata | input | W | Stack register write data |
| handler_mode | output | 1 | 1 = handler mode |
| user_level | output | 1 | 1 = unprivileged |
| stack_sel | output | 1 | 1 = process stack visible |
| sp_value | output | W | Value of the visible stack pointer |
| illegal_wr | output | 1 | One-cycle pulse on a denied privilege raise |

## Verification
All state sits in registers that load on one edge. The effect of an entry, a return, a control write or a stack write therefore shows on the outputs right after the edge that samples the request, and `illegal_wr` is high only during the cycle that follows. The bench drives inputs on the falling edge and advances its reference model on the rising edge. It then compares every output on the next falling edge, so each result is checked in the one cycle where it first becomes due. Random traffic with fixed odds is mixed with directed cases for same-cycle conflicts, handler-mode masking and stack bank isolation.

// File: rtl/priv_stack_ctrl.sv
module priv_stack_ctrl #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         exc_entry,
  input  logic         exc_return,
  input  logic         ret_explicit,
  input  logic         ret_handler,
  input  logic         ret_user,
  input  logic         ret_psp,
  input  logic         ctrl_wr,
  input  logic [1:0]   ctrl_wdata,
  input  logic         sp_wr,
  input  logic [W-1:0] sp_wdata,
  output logic         handler_mode,
  output logic         user_level,
  output logic         stack_sel,
  output logic [W-1:0] sp_value,
  output logic         illegal_wr
);
  logic hnd_q, npriv_q, psel_q;
  logic sv_hnd_q, sv_npriv_q, sv_psel_q;
  logic [W-1:2] msp_q, psp_q;
  logic ill_q;

  assign handler_mode = hnd_q;
  assign user_level   = npriv_q & ~hnd_q;
  assign stack_sel    = psel_q & ~hnd_q;
  assign sp_value     = {stack_sel ? psp_q : msp_q, 2'b00};
  assign illegal_wr   = ill_q;

  wire ctrl_ok = ctrl_wr & ~exc_entry & ~exc_return;
  wire priv_wr = ctrl_ok & ~user_level;
  wire denied  = ctrl_ok & user_level & ~ctrl_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hnd_q      <= 1'b0;
      npriv_q    <= 1'b0;
      psel_q     <= 1'b0;
      sv_hnd_q   <= 1'b0;
      sv_npriv_q <= 1'b0;
      sv_psel_q  <= 1'b0;
      ill_q      <= 1'b0;
    end else begin
      ill_q <= denied;
      if (exc_entry) begin
        sv_hnd_q   <= hnd_q;
        sv_npriv_q <= npriv_q;
        sv_psel_q  <= psel_q;
        hnd_q      <= 1'b1;
        npriv_q    <= 1'b0;
        psel_q     <= 1'b0;
      end else if (exc_return) begin
        hnd_q   <= ret_explicit ? ret_handler : sv_hnd_q;
        npriv_q <= ret_explicit ? ret_user    : sv_npriv_q;
        psel_q  <= ret_explicit ? ret_psp     : sv_psel_q;
      end else if (priv_wr) begin
        npriv_q <= ctrl_wdata[0];
        psel_q  <= ctrl_wdata[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msp_q <= '0;
      psp_q <= '0;
    end else if (sp_wr) begin
      if (stack_sel) psp_q <= sp_wdata[W-1:2];
      else           msp_q <= sp_wdata[W-1:2];
    end
  end

  // R2
  entry_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> handler_mode && !user_level && !stack_sel);

  // R6
  raise_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (user_level && !exc_entry && !exc_return) |=> user_level);

  // R6
  illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(illegal_wr) |-> $past(ctrl_wr && user_level && !ctrl_wdata[0]));

  // R8
  sp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_wr && !exc_entry && !exc_return && !ctrl_wr) |=>
      sp_value == {$past(sp_wdata[W-1:2]), 2'b00});

  // R9
  handler_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(handler_mode) |-> !stack_sel && !user_level);
endmodule

// File: tb/tb_priv_stack_ctrl.sv
module tb_priv_stack_ctrl;
  localparam int W = 32;
  logic clk = 0, rst_n = 0;
  logic exc_entry = 0, exc_return = 0, ret_explicit = 0, ret_handler = 0, ret_user = 0, ret_psp = 0;
  logic ctrl_wr = 0, sp_wr = 0;
  logic [1:0] ctrl_wdata = 0;
  logic [W-1:0] sp_wdata = 0;
  logic handler_mode, user_level, stack_sel, illegal_wr;
  logic [W-1:0] sp_value;
  int tests = 0, fails = 0;
  logic done = 0;

  // reference state
  logic m_h = 0, m_u = 0, m_p = 0, s_h = 0, s_u = 0, s_p = 0, m_ill = 0;
  logic [W-1:0] m_msp = 0, m_psp = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  priv_stack_ctrl #(.W(W)) dut (.*);

  function automatic logic e_user(); return m_u & ~m_h; endfunction
  function automatic logic e_sel();  return m_p & ~m_h; endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk(tag, handler_mode, m_h, "mode");
    chk(m_h ? "R9" : tag, user_level, e_user(), "privilege");
    chk(m_h ? "R9" : tag, stack_sel, e_sel(), "stack select");
    chk("R8", sp_value, e_sel() ? m_psp : m_msp, "sp");
    chk("R6", illegal_wr, m_ill, "illegal flag");
  endtask

  task automatic model_step();
    logic sel, usr;
    sel = e_sel(); usr = e_user();
    m_ill = 0;
    if (sp_wr) begin
      if (sel) m_psp = {sp_wdata[W-1:2], 2'b00};
      else     m_msp = {sp_wdata[W-1:2], 2'b00};
    end
    if (exc_entry) begin
      s_h = m_h; s_u = m_u; s_p = m_p;
      m_h = 1; m_u = 0; m_p = 0; tag = "R2";
    end else if (exc_return) begin
      if (ret_explicit) begin m_h = ret_handler; m_u = ret_user; m_p = ret_psp; tag = "R3"; end
      else begin m_h = s_h; m_u = s_u; m_p = s_p; tag = "R4"; end
    end else if (ctrl_wr) begin
      if (!usr) begin m_u = ctrl_wdata[0]; m_p = ctrl_wdata[1]; tag = "R5"; end
      else if (!ctrl_wdata[0]) begin m_ill = 1; tag = "R6"; end
      else tag = "R7";
    end else if (sp_wr) tag = "R8";
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
    exc_entry = 0; exc_return = 0; ctrl_wr = 0; sp_wr = 0;
  endtask

  task automatic ctrl(logic [1:0] d); ctrl_wr = 1; ctrl_wdata = d; cyc(); endtask
  task automatic spw(logic [W-1:0] d); sp_wr = 1; sp_wdata = d; cyc(); endtask
  task automatic ret(logic ex, logic h, logic u, logic p);
    exc_return = 1; ret_explicit = ex; ret_handler = h; ret_user = u; ret_psp = p; cyc();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    @(negedge clk);
    tag = "R1";
    check_all();
    @(negedge clk); rst_n = 1;
    @(negedge clk); tag = "R1"; check_all();
    // R8: main bank write, low bits dropped
    spw(32'h1234_5677);
    // R5: move to process stack, still privileged
    ctrl(2'b10);
    spw(32'hABCD_0003);               // R8 process bank
    ctrl(2'b00);                      // back to main: main intact
    chk("R8", sp_value, 32'h1234_5674, "main bank kept");
    ctrl(2'b11);                      // R5 unprivileged + process
    ctrl(2'b00);                      // R6 denied
    cyc();                            // flag must drop after one cycle (R6)
    ctrl(2'b01);                      // R7 tries to change stack select: no effect
    chk("R7", stack_sel, 1'b1, "stack select kept");
    // R2 with concurrent return and control write
    exc_entry = 1; exc_return = 1; ret_explicit = 1; ret_handler = 0; ret_user = 0; ret_psp = 0;
    ctrl_wr = 1; ctrl_wdata = 2'b00; cyc();
    // R9: handler writes and explicit handler return keep main/privileged
    ctrl(2'b11);
    ret(1, 1, 1, 1);
    chk("R9", {user_level, stack_sel}, 2'b00, "handler masking");
    ret(0, 0, 0, 0);                  // R4 restores unprivileged thread on process stack
    chk("R4", {handler_mode, user_level, stack_sel}, 3'b011, "restored state");
    exc_entry = 1; cyc();
    ret(1, 0, 0, 1);                  // R3 explicit privileged thread on process stack
    chk("R3", {handler_mode, user_level, stack_sel}, 3'b001, "explicit state");
    // R4: return wins over control write
    exc_return = 1; ret_explicit = 1; ret_handler = 0; ret_user = 0; ret_psp = 0;
    ctrl_wr = 1; ctrl_wdata = 2'b11; cyc();
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      exc_entry    = ($urandom % 10) == 0;
      exc_return   = ($urandom % 8) == 0;
      ret_explicit = $urandom % 2;
      ret_handler  = $urandom % 2;
      ret_user     = $urandom % 2;
      ret_psp      = $urandom % 2;
      ctrl_wr      = ($urandom % 4) == 0;
      ctrl_wdata   = 2'($urandom);
      sp_wr        = ($urandom % 3) == 0;
      sp_wdata     = $urandom;
      cyc();
    end
    // R1: reset mid-run
    rst_n = 0; #1;
    m_h = 0; m_u = 0; m_p = 0; s_h = 0; s_u = 0; s_p = 0; m_ill = 0; m_msp = 0; m_psp = 0; tag = "R1";
    @(negedge clk); check_all();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule